// File: doc/BRIEF.md
# Byte-Wide NOR Flash Behavioural Model

This block behaves like a byte-wide parallel NOR flash placed behind a simple synchronous bus with an address, a write byte, a read byte and one-cycle read and write strobes. A host reads the array directly. It changes the array only through command sequences, and each sequence opens with a two-write unlock prefix. Four operations are decoded: byte program, erase of one sector, erase of the whole array, and an identifier mode that returns a manufacturer byte and the device byte 0x49.

Programming can only pull bits from 1 to 0, because the stored value becomes the old byte ANDed with the written byte. Erase restores bytes to 0xFF, either for one sector or for the whole array. While an erase runs, the `ready` pin is low and reads return a status byte. Bit 7 of that byte is 0 and bit 6 flips on every read, so a host can poll for completion. Erase times are given in milliseconds and converted to clock cycles through `CYCLES_PER_MS`. The defaults shrink the array to 2 KB with 256-byte sectors so that simulation stays small. The full-size device is `ADDR_W=17`, `SEC_AW=14`. The array is a plain register memory that a bench can preload by hierarchical write.

Top module: `nf_flash_model`

## Requirements
- R1: After a synchronous active-low reset, `bus_rdata` is 0x00, `ready` is 1 and the block is in read-array mode.
- R2: In read-array mode, a read strobe with no erase running places the array byte at `bus_addr` on `bus_rdata` one clock later. Without a strobe, `bus_rdata` holds its value.
- R3: The program sequence is: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then one data write at the target address. Command addresses are compared on the low 11 address bits. The data write stores (old byte AND data), so writing 0xFF leaves the byte unchanged. A program takes effect at once and never lowers `ready`.
- R4: The sector erase sequence is: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at any address inside the sector. The sector is the address with its low `SEC_AW` bits cleared. Every byte of that sector becomes 0xFF and all other sectors keep their contents.
- R5: The chip erase sequence is the same as R4 but ends with 0x10 at 0x555. It sets every byte of the array to 0xFF.
- R6: `ready` falls in the cycle after the confirming erase write. It stays low for exactly `SEC_MS*CYCLES_PER_MS` cycles for a sector erase and exactly `CHIP_MS*CYCLES_PER_MS` cycles for a chip erase.
- R7: A read while `ready` is low returns a status byte with bit 7 = 0, bit 6 = toggle and bits 5..0 = 0. The toggle is 0 on the first status read after reset and inverts on every status read.
- R8: Writes issued while `ready` is low are ignored. They neither advance the command decoder nor change the array.
- R9: The sequence 0xAA at 0x555, 0x55 at 0x2AA, 0x90 at 0x555 enters identifier mode. In that mode a read with address bits [1:0] = 0 returns `MFR_CODE`, bits [1:0] = 1 returns 0x49 and any other value returns 0x00. The mode persists across reads until a 0xF0 write.
- R10: A write of 0xF0 returns the block to read-array mode from every command state except the one awaiting program data.
- R11: Any write that does not match the next expected step of a sequence returns the block to read-array mode without changing the array.
- R12: The program data write accepts any byte value, including 0xF0 and the command codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address for reads and command writes |
| bus_wdata | input | 8 | Write byte (command code or program data) |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 8 | Registered read result (array, identifier or status) |
| ready | output | 1 | High when no erase is in progress |

## Verification
If the command decoder is left in a wrong state, the fault shows up at the next write: a later program or erase lands where the host did not expect it, or fails to happen. It then shows on the first read of the affected byte after that write. If the erase timer or walker goes wrong, `ready` rises a cycle early or late, or a read right after completion returns a stale byte instead of 0xFF. Both are visible on the cycle of the event. A toggle fault shows on the second status poll. The bench compares `bus_rdata` and `ready` with a behavioural model after every clock, so any of these faults is reported within one cycle of becoming observable.

// File: rtl/nf_pkg.sv
// Shared types and command constants for the NOR flash model.
// Assumes command addresses are decoded on the low 11 address bits.
package nf_pkg;

    localparam int CMD_AW = 11;

    typedef enum logic [2:0] {
        CS_READ,   // read-array mode
        CS_U1,     // first unlock byte seen
        CS_U2,     // unlock pair complete, waiting for command code
        CS_PROG,   // waiting for program data
        CS_E80,    // erase setup seen
        CS_E1,     // erase: first unlock byte of second pair seen
        CS_E2,     // erase: second unlock pair complete
        CS_ID      // identifier mode
    } cmd_state_t;

    localparam logic [CMD_AW-1:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [CMD_AW-1:0] UNLOCK_ADDR_B = 11'h2AA;

    localparam logic [7:0] KEY_A      = 8'hAA;
    localparam logic [7:0] KEY_B      = 8'h55;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_SECTOR  = 8'h30;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_RESET   = 8'hF0;

endpackage

// File: rtl/nf_cmd_decoder.sv
// Command sequence decoder.
// Walks the unlock-prefixed command stream and raises one-cycle
// requests for program, sector erase and chip erase. Writes are
// ignored while busy is high. Assumes ADDR_W >= 11.
module nf_cmd_decoder
    import nf_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    output logic              prog_we,
    output logic              sec_go,
    output logic              chip_go,
    output logic              id_mode,
    output cmd_state_t        state
);

    cmd_state_t         nxt;
    logic [CMD_AW-1:0]  low;
    logic               wr_ok;
    logic               hit_a;
    logic               hit_b;
    logic               at_a;

    assign low   = addr[CMD_AW-1:0];
    assign wr_ok = wr && !busy;
    assign at_a  = (low == UNLOCK_ADDR_A);
    assign hit_a = at_a && (wdata == KEY_A);
    assign hit_b = (low == UNLOCK_ADDR_B) && (wdata == KEY_B);

    // Next-state and request decode for the current write.
    always_comb begin
        nxt     = state;
        prog_we = 1'b0;
        sec_go  = 1'b0;
        chip_go = 1'b0;
        if (wr_ok) begin
            unique case (state)
                CS_READ: if (hit_a) nxt = CS_U1;
                CS_U1:   nxt = hit_b ? CS_U2 : CS_READ;
                CS_U2: begin
                    if (at_a && wdata == OP_PROGRAM)    nxt = CS_PROG;
                    else if (at_a && wdata == OP_ERASE) nxt = CS_E80;
                    else if (at_a && wdata == OP_IDENT) nxt = CS_ID;
                    else                                nxt = CS_READ;
                end
                CS_PROG: begin
                    prog_we = 1'b1;
                    nxt     = CS_READ;
                end
                CS_E80: nxt = hit_a ? CS_E1 : CS_READ;
                CS_E1:  nxt = hit_b ? CS_E2 : CS_READ;
                CS_E2: begin
                    nxt = CS_READ;
                    if (wdata == OP_SECTOR)              sec_go  = 1'b1;
                    else if (at_a && wdata == OP_CHIP)   chip_go = 1'b1;
                end
                CS_ID: if (wdata == OP_RESET) nxt = CS_READ;
                default: nxt = CS_READ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CS_READ;
        else        state <= nxt;
    end

    assign id_mode = (state == CS_ID);

endmodule

// File: rtl/nf_erase_engine.sv
// Erase engine.
// On a start request it holds busy for a fixed cycle count and walks
// the target range one byte per cycle, requesting 0xFF writes.
// Assumes each busy window is at least as long as the range it wipes.
module nf_erase_engine #(
    parameter int ADDR_W        = 11,
    parameter int SEC_AW        = 8,
    parameter int CYCLES_PER_MS = 2,
    parameter int SEC_MS        = 500,
    parameter int CHIP_MS       = 4000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sec_go,
    input  logic                     chip_go,
    input  logic [ADDR_W-SEC_AW-1:0] sec_idx,
    output logic                     busy,
    output logic                     we,
    output logic [ADDR_W-1:0]        waddr
);

    localparam int SEC_CYC = SEC_MS * CYCLES_PER_MS;
    localparam int CHP_CYC = CHIP_MS * CYCLES_PER_MS;
    localparam int MAX_CYC = (SEC_CYC > CHP_CYC) ? SEC_CYC : CHP_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam int CNT_W   = ADDR_W + 1;
    localparam logic [CNT_W-1:0] ALL_BYTES = CNT_W'(1) << ADDR_W;
    localparam logic [CNT_W-1:0] SEC_BYTES = CNT_W'(1) << SEC_AW;

    logic [TMR_W-1:0]  tmr;
    logic [CNT_W-1:0]  left;
    logic [ADDR_W-1:0] ptr;

    // Start, walk and completion of an erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tmr  <= '0;
            left <= '0;
            ptr  <= '0;
        end else if (!busy && (sec_go || chip_go)) begin
            busy <= 1'b1;
            if (chip_go) begin
                tmr  <= TMR_W'(CHP_CYC - 1);
                left <= ALL_BYTES;
                ptr  <= '0;
            end else begin
                tmr  <= TMR_W'(SEC_CYC - 1);
                left <= SEC_BYTES;
                ptr  <= {sec_idx, {SEC_AW{1'b0}}};
            end
        end else if (busy) begin
            if (left != '0) begin
                left <= left - 1'b1;
                ptr  <= ptr + 1'b1;
            end
            if (tmr != '0)        tmr  <= tmr - 1'b1;
            else if (left == '0)  busy <= 1'b0;
        end
    end

    assign we    = busy && (left != '0);
    assign waddr = ptr;

endmodule

// File: rtl/nf_array.sv
// Byte array storage.
// One write port with an optional AND-merge and one combinational
// read port. Contents are not reset; a bench may preload mem.
module nf_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wand_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Write, either replacing or AND-merging with the stored byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wand_en ? (mem[waddr] & wdata) : wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nf_flash_model.sv
// Byte-wide NOR flash behavioural model (top).
// Joins the command decoder, erase engine and array, and registers
// the read result: status while busy, identifier bytes in ID mode,
// the array otherwise. Assumes bus_rd and bus_wr are not both high.
module nf_flash_model
    import nf_pkg::*;
#(
    parameter int         ADDR_W        = 11,
    parameter int         SEC_AW        = 8,
    parameter int         CYCLES_PER_MS = 2,
    parameter int         SEC_MS        = 500,
    parameter int         CHIP_MS       = 4000,
    parameter logic [7:0] MFR_CODE      = 8'hC2,
    parameter logic [7:0] DEV_CODE      = 8'h49
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              ready
);

    logic              busy;
    logic              prog_we;
    logic              sec_go;
    logic              chip_go;
    logic              id_mode;
    cmd_state_t        cmd_st;
    logic              ers_we;
    logic [ADDR_W-1:0] ers_addr;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata;
    logic [7:0]        arr_q;
    logic [7:0]        id_byte;
    logic              toggle;

    nf_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .busy    (busy),
        .prog_we (prog_we),
        .sec_go  (sec_go),
        .chip_go (chip_go),
        .id_mode (id_mode),
        .state   (cmd_st)
    );

    nf_erase_engine #(
        .ADDR_W        (ADDR_W),
        .SEC_AW        (SEC_AW),
        .CYCLES_PER_MS (CYCLES_PER_MS),
        .SEC_MS        (SEC_MS),
        .CHIP_MS       (CHIP_MS)
    ) u_ers (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_go  (sec_go),
        .chip_go (chip_go),
        .sec_idx (bus_addr[ADDR_W-1:SEC_AW]),
        .busy    (busy),
        .we      (ers_we),
        .waddr   (ers_addr)
    );

    // Write port arbitration: erase walker or a host program.
    always_comb begin
        arr_we    = ers_we || prog_we;
        arr_waddr = ers_we ? ers_addr : bus_addr;
        arr_wdata = ers_we ? 8'hFF : bus_wdata;
    end

    nf_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .we      (arr_we),
        .wand_en (!ers_we),
        .waddr   (arr_waddr),
        .wdata   (arr_wdata),
        .raddr   (bus_addr),
        .rdata   (arr_q)
    );

    // Identifier byte selected by the two low address bits.
    always_comb begin
        unique case (bus_addr[1:0])
            2'd0:    id_byte = MFR_CODE;
            2'd1:    id_byte = DEV_CODE;
            default: id_byte = 8'h00;
        endcase
    end

    // Registered read result and status toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
            toggle    <= 1'b0;
        end else if (bus_rd) begin
            if (busy) begin
                bus_rdata <= {1'b0, toggle, 6'b0};
                toggle    <= !toggle;
            end else if (id_mode) begin
                bus_rdata <= id_byte;
            end else begin
                bus_rdata <= arr_q;
            end
        end
    end

    assign ready = !busy;

endmodule

// File: rtl/nf_flash_chk.sv
// Assertion checker for nf_flash_model, attached by bind.
// Observes ports and signals driven by separate sub-blocks.
module nf_flash_chk
    import nf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       prog_we,
    input logic       ers_we,
    input logic       toggle,
    input cmd_state_t cmd_st
);

    // R1
    reset_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ready);

    // R6
    busy_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |=> !ready);

    // R8
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && bus_wr) |=> $stable(cmd_st));

    // R7
    status_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && bus_rd) |=> (toggle != $past(toggle)));

    // R3
    program_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> ready);

    // R4
    erase_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_we |-> !ready);

endmodule

bind nf_flash_model nf_flash_chk u_nf_flash_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (ready),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .prog_we (prog_we),
    .ers_we  (ers_we),
    .toggle  (toggle),
    .cmd_st  (cmd_st)
);

// File: tb/nf_flash_model_bench.sv
// Bench for nf_flash_model: behavioural reference model compared
// with bus_rdata and ready after every clock, plus directed checks.
module nf_flash_model_bench;

    localparam int AW       = 11;
    localparam int DEPTH    = 1 << AW;
    localparam int SEC_SZ   = 256;
    localparam int SEC_CYC  = 1000;
    localparam int CHIP_CYC = 8000;
    localparam logic [7:0] MFR = 8'hC2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    rdata;
    logic          ready;

    always #5 clk = ~clk;

    nf_flash_model u_nf_flash_model (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_rdata (rdata),
        .ready     (ready)
    );

    int    total = 0;
    int    bad = 0;
    int    low_cnt = 0;
    bit    seen = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state.
    logic [7:0] ref_mem [DEPTH];
    int         st = 0;
    int         busy_cnt = 0;
    bit         tog = 0;
    logic [7:0] exp_q = 8'h00;

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic model_write(input int a, input int d);
        int lo;
        lo = a & 12'h7FF;
        case (st)
            0: if (lo == 'h555 && d == 'hAA) st = 1;
            1: st = (lo == 'h2AA && d == 'h55) ? 2 : 0;
            2: begin
                if (lo == 'h555 && d == 'hA0)      st = 3;
                else if (lo == 'h555 && d == 'h80) st = 4;
                else if (lo == 'h555 && d == 'h90) st = 7;
                else                               st = 0;
            end
            3: begin ref_mem[a] = ref_mem[a] & 8'(d); st = 0; end
            4: st = (lo == 'h555 && d == 'hAA) ? 5 : 0;
            5: st = (lo == 'h2AA && d == 'h55) ? 6 : 0;
            6: begin
                st = 0;
                if (d == 'h30) begin
                    for (int k = 0; k < SEC_SZ; k++) ref_mem[(a / SEC_SZ) * SEC_SZ + k] = 8'hFF;
                    busy_cnt = SEC_CYC;
                end else if (lo == 'h555 && d == 'h10) begin
                    for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
                    busy_cnt = CHIP_CYC;
                end
            end
            7: if (d == 'hF0) st = 0;
            default: st = 0;
        endcase
    endtask

    // Reference model step on every rising edge.
    always @(posedge clk) begin
        bit was_busy;
        if (!rst_n) begin
            st = 0; busy_cnt = 0; tog = 0; exp_q = 8'h00;
        end else begin
            was_busy = (busy_cnt > 0);
            if (rd) begin
                if (was_busy) begin
                    exp_q = {1'b0, tog, 6'b0};
                    tog = ~tog;
                end else if (st == 7) begin
                    exp_q = (addr[1:0] == 0) ? MFR : (addr[1:0] == 1) ? 8'h49 : 8'h00;
                end else begin
                    exp_q = ref_mem[addr];
                end
            end
            if (was_busy) busy_cnt--;
            else if (wr) model_write(int'(addr), int'(wdata));
        end
        seen = 1;
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (seen && !done) begin
            total++;
            if (rdata !== exp_q || ready !== (busy_cnt == 0)) begin
                bad++;
                $display("FAIL %s: rdata=%h ready=%b expected rdata=%h ready=%b",
                         cur_req, rdata, ready, exp_q, (busy_cnt == 0));
            end
            if (ready === 1'b0) low_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        wr = 1'b1; addr = AW'(a); wdata = 8'(d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [7:0] v);
        @(negedge clk);
        rd = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic unlock();
        bus_write('h555, 'hAA);
        bus_write('h2AA, 'h55);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = pattern(i);
            u_nf_flash_model.u_arr.mem[i] = pattern(i);
        end
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 ready", ready, 1'b1);
        rst_n = 1'b1;

        cur_req = "R2";
        bus_read('h010, v); chk("R2 read 0x010", v, pattern('h010));
        bus_read('h3FF, v); chk("R2 read 0x3FF", v, pattern('h3FF));

        cur_req = "R3";
        unlock(); bus_write('h555, 'hA0); bus_write('h123, 'h5A);
        bus_read('h123, v); chk("R3 and-program", v, pattern('h123) & 8'h5A);
        unlock(); bus_write('h555, 'hA0); bus_write('h123, 'hFF);
        bus_read('h123, v); chk("R3 program 0xFF keeps", v, pattern('h123) & 8'h5A);
        chk("R3 ready stays high", ready, 1'b1);

        cur_req = "R12";
        unlock(); bus_write('h555, 'hA0); bus_write('h124, 'hF0);
        bus_read('h124, v); chk("R12 data 0xF0", v, pattern('h124) & 8'hF0);

        cur_req = "R9";
        unlock(); bus_write('h555, 'h90);
        bus_read('h000, v); chk("R9 maker", v, MFR);
        bus_read('h001, v); chk("R9 device", v, 8'h49);
        bus_read('h002, v); chk("R9 other", v, 8'h00);
        bus_read('h401, v); chk("R9 persists", v, 8'h49);

        cur_req = "R10";
        bus_write('h000, 'hF0);
        bus_read('h001, v); chk("R10 exit id", v, pattern('h001));
        unlock(); bus_write('h555, 'h80); bus_write('h000, 'hF0);
        bus_write('h150, 'h30);
        bus_read('h150, v); chk("R10 abort erase", v, pattern('h150));
        chk("R10 no busy", ready, 1'b1);

        cur_req = "R11";
        bus_write('h555, 'hAA); bus_write('h2AB, 'h55);
        bus_write('h555, 'hA0); bus_write('h200, 'h00);
        bus_read('h200, v); chk("R11 broken unlock", v, pattern('h200));

        cur_req = "R4";
        low_cnt = 0;
        unlock(); bus_write('h555, 'h80); unlock(); bus_write('h1A5, 'h30);
        cur_req = "R7";
        bus_read('h100, v); chk("R7 first status", v, 8'h00);
        bus_read('h100, v); chk("R7 second status", v, 8'h40);
        cur_req = "R8";
        unlock(); bus_write('h555, 'hA0); bus_write('h300, 'h00);
        while (ready !== 1'b1) @(negedge clk);
        cur_req = "R6";
        chk("R6 sector busy cycles", low_cnt, SEC_CYC);
        cur_req = "R4";
        bus_read('h100, v); chk("R4 sector low", v, 8'hFF);
        bus_read('h1FF, v); chk("R4 sector high", v, 8'hFF);
        bus_read('h0FF, v); chk("R4 below sector", v, pattern('h0FF));
        bus_read('h200, v); chk("R4 above sector", v, pattern('h200));
        bus_read('h300, v); chk("R8 busy program ignored", v, pattern('h300));
        bus_write('h300, 'h00);
        bus_read('h300, v); chk("R8 decoder not advanced", v, pattern('h300));

        cur_req = "R5";
        low_cnt = 0;
        unlock(); bus_write('h555, 'h80); unlock(); bus_write('h555, 'h10);
        while (ready !== 1'b1) @(negedge clk);
        chk("R6 chip busy cycles", low_cnt, CHIP_CYC);
        bus_read('h000, v); chk("R5 first byte", v, 8'hFF);
        bus_read('h7FF, v); chk("R5 last byte", v, 8'hFF);
        bus_read('h124, v); chk("R5 programmed byte", v, 8'hFF);

        cur_req = "R3";
        unlock(); bus_write('h555, 'hA0); bus_write('h055, 'h3C);
        bus_read('h055, v); chk("R3 program after erase", v, 8'h3C);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule